// File: doc/BRIEF.md
# Multi-function pin bank controller

The block manages one bank of pads. For every pin it decides who drives the pad: the general-purpose output logic, or one of four internal peripheral functions named A, B, C and D. It also holds per-pin settings for output enable, output data, pull-up, pull-down, open-drain drive and Schmitt-trigger disable, and it reports the live pad level.

Software reaches the block through a simple word-addressed register bus. Most per-pin state lives in set/clear register pairs: a 1 in a written bit sets or clears that pin's bit, and a 0 leaves it alone. Each pair has a status word where the current vector can be read. Pad-side signals and the inputs returned to the peripherals are registered, so they follow the configuration one clock after the write.

Top module: `padbank_ctrl`

## Requirements
- R1: After synchronous reset every pin is GPIO-owned, output drive is off, pull-up is on, pull-down is off, open-drain is off, the data latch is 0, both select words are 0 and the Schmitt word is 0. Reads of the status words return these values.
- R2: Each set/clear pair sits at word offsets 3k (set), 3k+1 (clear) and 3k+2 (status), with k=0 ownership (1 = GPIO), k=1 output enable, k=2 pull-up, k=3 pull-down and k=4 open-drain. Writing the set word sets the bits written as 1. Writing the clear word clears those bits. Bits written as 0 stay unchanged.
- R3: The output data latch is pair k=5 (offsets 15, 16, 17). Its set word drives the chosen latch bits high and its clear word drives them low.
- R4: The function select words are plain read/write registers: sel1 is at offset 18 and sel2 at offset 19. For a peripheral-owned pin, {sel2,sel1} = 00, 01, 10, 11 selects function A, B, C, D (index 0..3). The pad output and enable come from that function. Only that function's input bit carries the pad level, and all other function inputs for the pin read 0.
- R5: For a GPIO-owned pin, the pad output comes from the data latch and the pad enable comes from the output-enable register. No function input sees the pad.
- R6: With open-drain on, the pad output is 0 and the pad enable is (source enable AND NOT source value). This applies to both GPIO and peripheral sources.
- R7: The pull-up output follows the pull-up register. The pull-down output is the pull-down register masked by NOT pull-up, so the two never assert together.
- R8: The Schmitt word at offset 20 is read/write, and a 1 bit asserts pad_st_off for that pin.
- R9: A read of offset 21 returns the pad_in level sampled at the read edge, whatever the pin's ownership.
- R10: Pad and function-input outputs change on the second rising edge after the write is presented. They reflect the new state one clock after the register update. Read data is registered and is valid after the edge that samples bus_rd.
- R11: Writes to status offsets (3k+2), offset 21 and unmapped offsets change no state. Reads of unmapped offsets (22 and above) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Word offset |
| bus_wdata | input | NPIN | Write data, one bit per pin |
| bus_rdata | output | NPIN | Registered read data |
| fn_out | input | NFUNC x NPIN | Output value from each peripheral function |
| fn_oe | input | NFUNC x NPIN | Output enable from each peripheral function |
| fn_in | output | NFUNC x NPIN | Pad level returned to the selected function |
| pad_in | input | NPIN | Live pad level |
| pad_out | output | NPIN | Pad output value |
| pad_oe | output | NPIN | Pad output enable |
| pad_pu | output | NPIN | Pull-up control |
| pad_pd | output | NPIN | Pull-down control |
| pad_st_off | output | NPIN | Schmitt-trigger disable |

## Verification
The mux is swept with all four function codes rotated across all 32 pins. In each sweep pass every pin sees a different code, so a swapped select bit or a wrong function index shows up on some pin. The function inputs are driven with distinct random words, so a source picked from the wrong function is visible. Directed set/clear sequences with overlapping masks show whether zero bits are really left alone. The open-drain and pull cases are exercised with source value and source enable in all combinations. A long random run of writes and reads, including status, read-only and unmapped offsets, is compared against an arithmetic model of the registers.

// File: rtl/padbank_pkg.sv
package padbank_pkg;
  localparam int NFUNC    = 4;
  localparam int NPAIR    = 6;
  localparam int PAIR_OWN = 0;
  localparam int PAIR_OE  = 1;
  localparam int PAIR_PU  = 2;
  localparam int PAIR_PD  = 3;
  localparam int PAIR_OD  = 4;
  localparam int PAIR_DAT = 5;
  localparam int OFS_SEL1 = 3 * NPAIR;
  localparam int OFS_SEL2 = OFS_SEL1 + 1;
  localparam int OFS_SCH  = OFS_SEL1 + 2;
  localparam int OFS_LVL  = OFS_SEL1 + 3;
endpackage

// File: rtl/padbank_setclr.sv
module padbank_setclr #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= RST_VAL;
    else if (set_we) q <= q | wmask;
    else if (clr_we) q <= q & ~wmask;
  end

  a_r2_set_bits: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((q & $past(wmask)) == $past(wmask)));
  a_r2_clr_bits: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((q & $past(wmask)) == '0));
  a_r2_zero_bits_kept: assert property (@(posedge clk) disable iff (rst)
    (set_we || clr_we) |=> (((q ^ $past(q)) & ~$past(wmask)) == '0));
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(q));
endmodule

// File: rtl/padbank_mux.sv
module padbank_mux #(
  parameter int NPIN  = 32,
  parameter int NFUNC = 4
) (
  input  logic [NPIN-1:0]             own_gpio,
  input  logic [NPIN-1:0]             gpio_oe,
  input  logic [NPIN-1:0]             gpio_dat,
  input  logic [NPIN-1:0]             od_en,
  input  logic [NPIN-1:0]             sel1,
  input  logic [NPIN-1:0]             sel2,
  input  logic [NFUNC-1:0][NPIN-1:0]  fn_out,
  input  logic [NFUNC-1:0][NPIN-1:0]  fn_oe,
  input  logic [NPIN-1:0]             pad_in,
  output logic [NPIN-1:0]             nxt_out,
  output logic [NPIN-1:0]             nxt_oe,
  output logic [NFUNC-1:0][NPIN-1:0]  nxt_fn_in
);
  localparam int FW = $clog2(NFUNC);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [FW-1:0] fsel;
    logic          src_o, src_e;
    assign fsel  = FW'({sel2[i], sel1[i]});
    assign src_o = own_gpio[i] ? gpio_dat[i] : fn_out[fsel][i];
    assign src_e = own_gpio[i] ? gpio_oe[i]  : fn_oe[fsel][i];
    assign nxt_out[i] = od_en[i] ? 1'b0 : src_o;
    assign nxt_oe[i]  = od_en[i] ? (src_e & ~src_o) : src_e;
    for (genvar f = 0; f < NFUNC; f++) begin : g_fn
      assign nxt_fn_in[f][i] = !own_gpio[i] && (fsel == FW'(f)) && pad_in[i];
    end
  end
endmodule

// File: rtl/padbank_ctrl.sv
module padbank_ctrl
  import padbank_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [AW-1:0]              bus_addr,
  input  logic [NPIN-1:0]            bus_wdata,
  output logic [NPIN-1:0]            bus_rdata,
  input  logic [NFUNC-1:0][NPIN-1:0] fn_out,
  input  logic [NFUNC-1:0][NPIN-1:0] fn_oe,
  output logic [NFUNC-1:0][NPIN-1:0] fn_in,
  input  logic [NPIN-1:0]            pad_in,
  output logic [NPIN-1:0]            pad_out,
  output logic [NPIN-1:0]            pad_oe,
  output logic [NPIN-1:0]            pad_pu,
  output logic [NPIN-1:0]            pad_pd,
  output logic [NPIN-1:0]            pad_st_off
);
  logic [NPIN-1:0] pair_q [NPAIR];
  logic [NPIN-1:0] sel1_q, sel2_q, sch_q;
  logic [NPIN-1:0] rd_nxt, mux_out, mux_oe;
  logic [NFUNC-1:0][NPIN-1:0] mux_fn_in;

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    localparam logic [NPIN-1:0] RV =
      (k == PAIR_OWN || k == PAIR_PU) ? {NPIN{1'b1}} : {NPIN{1'b0}};
    padbank_setclr #(.W(NPIN), .RST_VAL(RV)) u_reg (
      .clk    (clk),
      .rst    (rst),
      .set_we (bus_wr && bus_addr == AW'(3 * k)),
      .clr_we (bus_wr && bus_addr == AW'(3 * k + 1)),
      .wmask  (bus_wdata),
      .q      (pair_q[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel1_q <= '0;
      sel2_q <= '0;
      sch_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == AW'(OFS_SEL1)) sel1_q <= bus_wdata;
      if (bus_addr == AW'(OFS_SEL2)) sel2_q <= bus_wdata;
      if (bus_addr == AW'(OFS_SCH))  sch_q  <= bus_wdata;
    end
  end

  always_comb begin
    rd_nxt = '0;
    for (int k = 0; k < NPAIR; k++)
      if (bus_addr == AW'(3 * k + 2)) rd_nxt = pair_q[k];
    if (bus_addr == AW'(OFS_SEL1)) rd_nxt = sel1_q;
    if (bus_addr == AW'(OFS_SEL2)) rd_nxt = sel2_q;
    if (bus_addr == AW'(OFS_SCH))  rd_nxt = sch_q;
    if (bus_addr == AW'(OFS_LVL))  rd_nxt = pad_in;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_nxt;
  end

  padbank_mux #(.NPIN(NPIN), .NFUNC(NFUNC)) u_mux (
    .own_gpio  (pair_q[PAIR_OWN]),
    .gpio_oe   (pair_q[PAIR_OE]),
    .gpio_dat  (pair_q[PAIR_DAT]),
    .od_en     (pair_q[PAIR_OD]),
    .sel1      (sel1_q),
    .sel2      (sel2_q),
    .fn_out    (fn_out),
    .fn_oe     (fn_oe),
    .pad_in    (pad_in),
    .nxt_out   (mux_out),
    .nxt_oe    (mux_oe),
    .nxt_fn_in (mux_fn_in)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out    <= '0;
      pad_oe     <= '0;
      pad_pu     <= '0;
      pad_pd     <= '0;
      pad_st_off <= '0;
      fn_in      <= '0;
    end else begin
      pad_out    <= mux_out;
      pad_oe     <= mux_oe;
      pad_pu     <= pair_q[PAIR_PU];
      pad_pd     <= pair_q[PAIR_PD] & ~pair_q[PAIR_PU];
      pad_st_off <= sch_q;
      fn_in      <= mux_fn_in;
    end
  end

  a_r7_pull_exclusive: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0);
  a_r6_open_drain_low: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_out & $past(pair_q[PAIR_OD])) == '0));
  a_r5_gpio_no_fn_in: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((fn_in[0] | fn_in[1] | fn_in[2] | fn_in[3]) & $past(pair_q[PAIR_OWN])) == '0);
  for (genvar i = 0; i < NPIN; i++) begin : g_chk
    logic [NFUNC-1:0] col;
    for (genvar f = 0; f < NFUNC; f++) begin : g_col
      assign col[f] = fn_in[f][i];
    end
    a_r4_fn_in_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col));
  end
endmodule

// File: tb/tb_padbank_ctrl.sv
module tb_padbank_ctrl;
  localparam int NPIN = 32;
  localparam int AW   = 5;
  localparam int NF   = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [NPIN-1:0] bus_wdata, bus_rdata, pad_in;
  logic [NPIN-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_st_off;
  logic [NF-1:0][NPIN-1:0] fn_out, fn_oe, fn_in;

  padbank_ctrl #(.NPIN(NPIN), .AW(AW)) dut (.*);

  logic [NPIN-1:0] m_own, m_oe, m_pu, m_pd, m_od, m_dat, m_s1, m_s2, m_sch;
  logic [NPIN-1:0] e_out, e_oe;
  logic [NF-1:0][NPIN-1:0] e_in;
  int total = 0, bad = 0;

  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      int f;
      logic so, se;
      f  = 2 * int'(m_s2[i]) + int'(m_s1[i]);
      so = m_own[i] ? m_dat[i] : fn_out[f][i];
      se = m_own[i] ? m_oe[i]  : fn_oe[f][i];
      e_out[i] = m_od[i] ? 1'b0 : so;
      e_oe[i]  = m_od[i] ? (se & ~so) : se;
      for (int g = 0; g < NF; g++) e_in[g][i] = !m_own[i] && f == g && pad_in[i];
    end
  end

  task automatic chk(string req, logic [NPIN-1:0] act, logic [NPIN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NPIN-1:0] exp_read(int a);
    case (a)
      2: return m_own;   5: return m_oe;   8: return m_pu;
      11: return m_pd;   14: return m_od;  17: return m_dat;
      18: return m_s1;   19: return m_s2;  20: return m_sch;
      21: return pad_in;
      default: return '0;
    endcase
  endfunction

  task automatic do_wr(int a, logic [NPIN-1:0] w);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = w;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      0: m_own |= w;  1: m_own &= ~w;
      3: m_oe  |= w;  4: m_oe  &= ~w;
      6: m_pu  |= w;  7: m_pu  &= ~w;
      9: m_pd  |= w;  10: m_pd &= ~w;
      12: m_od |= w;  13: m_od &= ~w;
      15: m_dat |= w; 16: m_dat &= ~w;
      18: m_s1 = w;   19: m_s2 = w;  20: m_sch = w;
      default: ;
    endcase
  endtask

  task automatic do_rd(int a, string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, exp_read(a));
  endtask

  task automatic check_pads(string req);
    @(negedge clk);
    chk({req, " pad_out"}, pad_out, e_out);
    chk({req, " pad_oe"}, pad_oe, e_oe);
    chk("R7 pad_pu", pad_pu, m_pu);
    chk("R7 pad_pd", pad_pd, m_pd & ~m_pu);
    chk("R8 pad_st_off", pad_st_off, m_sch);
    for (int g = 0; g < NF; g++) chk({req, " fn_in"}, fn_in[g], e_in[g]);
  endtask

  task automatic rand_ins();
    for (int g = 0; g < NF; g++) begin
      fn_out[g] = $urandom;
      fn_oe[g]  = $urandom;
    end
    pad_in = $urandom;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    fn_out = '0; fn_oe = '0; pad_in = '0;
    m_own = '1; m_oe = '0; m_pu = '1; m_pd = '0; m_od = '0; m_dat = '0;
    m_s1 = '0; m_s2 = '0; m_sch = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state through status words and pads
    check_pads("R1");
    for (int a = 2; a <= 20; a += 3) do_rd(a, "R1 status");
    do_rd(18, "R1 sel1"); do_rd(19, "R1 sel2"); do_rd(20, "R1 schmitt");

    // R2: overlapping set and clear masks
    do_wr(3, 32'h0000_00F0);
    do_wr(3, 32'h0000_000F);
    do_wr(4, 32'h0000_0030);
    do_rd(5, "R2 oe status");
    chk("R2 oe value", exp_read(5), 32'h0000_00CF);
    do_wr(13, 32'hFFFF_FFFF);
    do_wr(12, 32'h8000_0001);
    do_rd(14, "R2 od status");

    // R3 and R10: data latch set/clear with one-cycle output delay
    do_wr(4, '1); do_wr(12 + 1, '1); do_wr(3, '1);
    check_pads("R5");
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(15); bus_wdata = 32'hA5A5_0F0F;
    @(negedge clk);
    bus_wr = 1'b0; m_dat |= 32'hA5A5_0F0F;
    chk("R10 pad_out not yet", pad_out, 32'h0);
    @(negedge clk);
    chk("R10 pad_out updated", pad_out, 32'hA5A5_0F0F);
    do_wr(16, 32'h0000_FFFF);
    check_pads("R3");
    do_rd(17, "R3 data status");

    // R11: status, level and unmapped writes are ignored
    do_wr(5, 32'h1234_5678); do_wr(17, '1); do_wr(21, '1); do_wr(25, '1);
    for (int a = 2; a <= 20; a += 3) do_rd(a, "R11 status kept");
    do_rd(18, "R11 sel1"); do_rd(20, "R11 sch");
    do_rd(22, "R11 unmapped"); do_rd(31, "R11 unmapped");
    check_pads("R11");

    // R4: every pin through all four codes, rotated across pins
    do_wr(1, '1);
    for (int k = 0; k < NF; k++) begin
      logic [NPIN-1:0] s1, s2;
      for (int i = 0; i < NPIN; i++) begin
        s1[i] = ((i + k) % 4) & 1;
        s2[i] = ((i + k) % 4) >> 1;
      end
      do_wr(18, s1); do_wr(19, s2);
      for (int r = 0; r < 3; r++) begin
        rand_ins();
        check_pads("R4");
      end
    end

    // R9: level read under mixed ownership
    do_wr(0, 32'h0F0F_0F0F);
    for (int r = 0; r < 4; r++) begin
      rand_ins();
      do_rd(21, "R9 level");
    end

    // R6: open-drain on both GPIO and peripheral pins
    do_wr(12, '1);
    for (int r = 0; r < 6; r++) begin
      rand_ins();
      do_wr(15, $urandom); do_wr(16, $urandom);
      check_pads("R6");
    end
    do_wr(13, '1);

    // R7: pull combinations
    do_wr(9, '1); check_pads("R7");
    do_wr(7, 32'hFF00_FF00); check_pads("R7");
    do_wr(10, 32'h00FF_0000); check_pads("R7");

    // R8: Schmitt word
    do_wr(20, 32'hDEAD_BEEF); do_rd(20, "R8 rw"); check_pads("R8");

    // R2/R11: random writes and reads against the model
    for (int n = 0; n < 300; n++) begin
      rand_ins();
      do_wr(int'($urandom % 24), $urandom);
      check_pads("R2 random");
      do_rd(int'($urandom % 32), "R11 random read");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule